// File: doc/BRIEF.md
# Configurable Register Cell with Clock Source Selection

This block is one storage cell of a programmable logic array. It takes a sum-of-products value from the term allocator and passes it through a polarity inverter. A direct pad input can be chosen in place of that path. The chosen bit is held in a storage element that is configured as an edge-triggered D register, a toggle register or a level-transparent latch. A bypass setting sends the inverter output straight to the outputs instead.

The storage element is timed by one of eight clock sources. These are four block-wide clocks, a clock term shared across the block, the true form of the cell's own clock term, the inverted form of that term, and a constant low. Reset and preset come either from a shared pair of initialization terms or from the cell's own terms. One of the cell's own terms can serve as a clock enable instead. A configuration bit sets the value the cell takes at power-up.

All clock-source levels are sampled by one system clock. A rising edge of the selected source is detected inside the block, so the cell fits into a single-clock design. Reset and preset are level-sensitive and act on the first system clock edge where they are high, whatever the selected source is doing.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst` is high, the stored bit takes the value of `cfg_pwr_val` on every system clock edge, and the detector's previous-level record is set to 1.
- R2: With `cfg_bypass` = 1, both outputs equal `logic_sum XOR cfg_xor_inv` combinationally, whatever the stored bit is.
- R3: With `cfg_mode` = 0 (D register; code 3 acts the same), the stored bit loads the data bit on a system edge where the selected source is 1 and was 0 at the previous system edge, provided the enable is active.
- R4: With `cfg_mode` = 1 (toggle), the stored bit inverts on a detected rising edge of the selected source when the data bit is 1 and the enable is active, and holds otherwise.
- R5: With `cfg_mode` = 2 (latch), the stored bit loads the data bit on every system edge where the selected source level is 1 and the enable is active, and holds while that level is 0.
- R6: `cfg_clk_sel` values 0 to 3 select `blk_clk[0]` to `blk_clk[3]`. Value 4 selects `sh_clk_pt`, 5 selects `ind_clk_pt`, 6 selects the inverse of `ind_clk_pt`, and 7 selects a constant 0, so the stored bit never updates from data.
- R7: With `cfg_ce_en` = 1, `ind_pre_ce_pt` is the enable and a 0 on it blocks every data update. With `cfg_ce_en` = 0, the enable is always active.
- R8: With `cfg_init_ind` = 0, reset is `sh_rst_pt` and preset is `sh_pre_pt`. With `cfg_init_ind` = 1, reset is `ind_rst_pt` and preset is `ind_pre_ce_pt` (masked to 0 when `cfg_ce_en` = 1). Reset clears the bit, preset sets it, reset wins over preset, and both override the clock and the enable.
- R9: With `cfg_io_sel` = 1, the data bit is `io_in` without inversion. With `cfg_io_sel` = 0, it is `logic_sum XOR cfg_xor_inv`.
- R10: `orp_out` and `grp_out` always carry the same value: the stored bit when the bypass is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock-source levels |
| rst | input | 1 | Synchronous power-up initialization, active high |
| cfg_clk_sel | input | 3 | Clock source code |
| cfg_mode | input | 2 | Storage mode: 0 D, 1 toggle, 2 latch |
| cfg_xor_inv | input | 1 | Inverts the logic sum |
| cfg_bypass | input | 1 | Routes the inverter output past the storage |
| cfg_io_sel | input | 1 | Takes data from the pad input |
| cfg_init_ind | input | 1 | Uses the cell's own init terms instead of the shared ones |
| cfg_ce_en | input | 1 | Turns the cell's second own term into a clock enable |
| cfg_pwr_val | input | 1 | Power-up value of the stored bit |
| blk_clk | input | 4 | Block-wide clock levels |
| sh_clk_pt | input | 1 | Shared clock term level |
| ind_clk_pt | input | 1 | Cell's own clock term level |
| sh_rst_pt | input | 1 | Shared reset term |
| sh_pre_pt | input | 1 | Shared preset term |
| ind_rst_pt | input | 1 | Cell's own reset term |
| ind_pre_ce_pt | input | 1 | Cell's own preset or enable term |
| logic_sum | input | 1 | Sum from the term allocator |
| io_in | input | 1 | Direct pad input |
| orp_out | output | 1 | Value toward output routing |
| grp_out | output | 1 | Value toward global routing |

## Verification
The bench sweeps all eight clock codes against every storage mode, both data paths and both polarities. Pseudo-random levels drive the clocks, terms and remaining configuration bits, and a bench-side model built from the requirements gives the expected outputs. A cell that treats the inverted clock term as the true one would update on the wrong transitions at code 6. A constant source that was not tied low would let code 7 load data. A toggle cell that reloads instead of inverting would track the data bit. Directed checks drive reset and preset together to expose a reversed priority, and they check both power-up values, which exposes a fixed reset value.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_DREG  = 2'd0,
        MODE_TOGL  = 2'd1,
        MODE_LATCH = 2'd2,
        MODE_DALT  = 2'd3
    } mc_mode_e;

    typedef struct packed {
        mc_mode_e mode;
        logic     inv;
        logic     bypass;
        logic     io_sel;
        logic     init_ind;
        logic     ce_en;
        logic     pwr_val;
    } mc_cfg_t;

    localparam int EXTRA_SRCS = 4;

    function automatic int csel_width(input int nblk);
        return $clog2(nblk + EXTRA_SRCS);
    endfunction

    function automatic logic next_bit(input mc_mode_e m, input logic cur,
                                      input logic din, input logic edge_hit,
                                      input logic lvl);
        logic r;
        r = cur;
        case (m)
            MODE_TOGL:  if (edge_hit && din) r = ~cur;
            MODE_LATCH: if (lvl) r = din;
            default:    if (edge_hit) r = din;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
    parameter int NUM_BLK = 4,
    parameter int CSEL_W  = mc_pkg::csel_width(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CSEL_W-1:0]  sel,
    input  logic [NUM_BLK-1:0] blk_clk,
    input  logic               sh_clk,
    input  logic               ind_clk,
    output logic               lvl,
    output logic               rise
);
    localparam int NSRC = 1 << CSEL_W;

    logic [NSRC-1:0] srcs;
    logic            prev_lvl;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g < NUM_BLK) begin : g_blk
            assign srcs[g] = blk_clk[g];
        end else if (g == NUM_BLK) begin : g_sh
            assign srcs[g] = sh_clk;
        end else if (g == NUM_BLK + 1) begin : g_true
            assign srcs[g] = ind_clk;
        end else if (g == NUM_BLK + 2) begin : g_comp
            assign srcs[g] = ~ind_clk;
        end else begin : g_tie
            assign srcs[g] = 1'b0;
        end
    end

    assign lvl  = srcs[sel];
    assign rise = lvl & ~prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= 1'b1;
        else     prev_lvl <= lvl;
    end
endmodule

// File: rtl/mc_init_ctl.sv
module mc_init_ctl (
    input  logic init_ind,
    input  logic ce_en,
    input  logic sh_rst,
    input  logic sh_pre,
    input  logic ind_rst,
    input  logic ind_pre_ce,
    output logic eff_rst,
    output logic eff_pre,
    output logic eff_ce
);
    always_comb begin
        if (init_ind) begin
            eff_rst = ind_rst;
            eff_pre = ce_en ? 1'b0 : ind_pre_ce;
        end else begin
            eff_rst = sh_rst;
            eff_pre = sh_pre;
        end
        eff_ce = ce_en ? ind_pre_ce : 1'b1;
    end
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mc_cfg_t cfg,
    input  logic    din,
    input  logic    lvl,
    input  logic    rise,
    input  logic    eff_rst,
    input  logic    eff_pre,
    input  logic    eff_ce,
    output logic    q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= cfg.pwr_val;
        else if (eff_rst) q <= 1'b0;
        else if (eff_pre) q <= 1'b1;
        else if (eff_ce)  q <= next_bit(cfg.mode, q, din, rise, lvl);
    end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_BLK = 4,
    localparam int CSEL_W = csel_width(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CSEL_W-1:0]  cfg_clk_sel,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_xor_inv,
    input  logic               cfg_bypass,
    input  logic               cfg_io_sel,
    input  logic               cfg_init_ind,
    input  logic               cfg_ce_en,
    input  logic               cfg_pwr_val,
    input  logic [NUM_BLK-1:0] blk_clk,
    input  logic               sh_clk_pt,
    input  logic               ind_clk_pt,
    input  logic               sh_rst_pt,
    input  logic               sh_pre_pt,
    input  logic               ind_rst_pt,
    input  logic               ind_pre_ce_pt,
    input  logic               logic_sum,
    input  logic               io_in,
    output logic               orp_out,
    output logic               grp_out
);
    mc_cfg_t cfg;
    logic    xor_out;
    logic    din_sel;
    logic    src_lvl;
    logic    src_rise;
    logic    ctl_rst;
    logic    ctl_pre;
    logic    ctl_ce;
    logic    q_reg;
    logic    cell_out;

    always_comb begin
        cfg.mode     = mc_mode_e'(cfg_mode);
        cfg.inv      = cfg_xor_inv;
        cfg.bypass   = cfg_bypass;
        cfg.io_sel   = cfg_io_sel;
        cfg.init_ind = cfg_init_ind;
        cfg.ce_en    = cfg_ce_en;
        cfg.pwr_val  = cfg_pwr_val;
    end

    assign xor_out = logic_sum ^ cfg.inv;
    assign din_sel = cfg.io_sel ? io_in : xor_out;

    mc_clk_sel #(.NUM_BLK(NUM_BLK), .CSEL_W(CSEL_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .sel     (cfg_clk_sel),
        .blk_clk (blk_clk),
        .sh_clk  (sh_clk_pt),
        .ind_clk (ind_clk_pt),
        .lvl     (src_lvl),
        .rise    (src_rise)
    );

    mc_init_ctl u_init (
        .init_ind   (cfg.init_ind),
        .ce_en      (cfg.ce_en),
        .sh_rst     (sh_rst_pt),
        .sh_pre     (sh_pre_pt),
        .ind_rst    (ind_rst_pt),
        .ind_pre_ce (ind_pre_ce_pt),
        .eff_rst    (ctl_rst),
        .eff_pre    (ctl_pre),
        .eff_ce     (ctl_ce)
    );

    mc_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .din     (din_sel),
        .lvl     (src_lvl),
        .rise    (src_rise),
        .eff_rst (ctl_rst),
        .eff_pre (ctl_pre),
        .eff_ce  (ctl_ce),
        .q       (q_reg)
    );

    assign cell_out = cfg.bypass ? xor_out : q_reg;
    assign orp_out  = cell_out;
    assign grp_out  = cell_out;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
    parameter int NUM_BLK = 4,
    parameter int CSEL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [CSEL_W-1:0] cfg_clk_sel,
    input logic [1:0]        cfg_mode,
    input logic              cfg_pwr_val,
    input logic              cfg_ce_en,
    input logic              ind_pre_ce_pt,
    input logic              eff_rst,
    input logic              eff_pre,
    input logic              eff_ce,
    input logic              src_rise,
    input logic              din,
    input logic              q
);
    localparam logic [CSEL_W-1:0] SEL_TIED = CSEL_W'(NUM_BLK + 3);

    assert_pwrup_R1: assert property (@(posedge clk)
        rst |=> q == $past(cfg_pwr_val));

    assert_dload_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd0 && src_rise && eff_ce && !eff_rst && !eff_pre)
        |=> q == $past(din));

    assert_toggle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd1 && !din && !eff_rst && !eff_pre) |=> $stable(q));

    assert_tied_src_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_clk_sel == SEL_TIED && !eff_rst && !eff_pre) |=> $stable(q));

    assert_ce_block_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_ce_en && !ind_pre_ce_pt && !eff_rst && !eff_pre) |=> $stable(q));

    assert_reset_wins_R8: assert property (@(posedge clk) disable iff (rst)
        eff_rst |=> !q);

    assert_preset_R8: assert property (@(posedge clk) disable iff (rst)
        (eff_pre && !eff_rst) |=> q);
endmodule

bind mc_macrocell mc_macrocell_chk #(.NUM_BLK(NUM_BLK), .CSEL_W(CSEL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_clk_sel   (cfg_clk_sel),
    .cfg_mode      (cfg_mode),
    .cfg_pwr_val   (cfg_pwr_val),
    .cfg_ce_en     (cfg_ce_en),
    .ind_pre_ce_pt (ind_pre_ce_pt),
    .eff_rst       (ctl_rst),
    .eff_pre       (ctl_pre),
    .eff_ce        (ctl_ce),
    .src_rise      (src_rise),
    .din           (din_sel),
    .q             (q_reg)
);

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_clk_sel = '0;
    logic [1:0] cfg_mode = '0;
    logic       cfg_xor_inv = 0, cfg_bypass = 0, cfg_io_sel = 0;
    logic       cfg_init_ind = 0, cfg_ce_en = 0, cfg_pwr_val = 0;
    logic [3:0] blk_clk = '0;
    logic       sh_clk_pt = 0, ind_clk_pt = 0;
    logic       sh_rst_pt = 0, sh_pre_pt = 0, ind_rst_pt = 0, ind_pre_ce_pt = 0;
    logic       logic_sum = 0, io_in = 0;
    logic       orp_out, grp_out;

    int errors = 0;
    int checks = 0;
    logic exp_q = 0;
    logic exp_prev = 1;
    logic [31:0] rng = 32'h1234_5679;

    mc_macrocell u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (sel=%0d mode=%0d)",
                     req, act, exp, cfg_clk_sel, cfg_mode);
        end
    endtask

    // Model of one system edge, from the requirements.
    task automatic tick();
        logic lvl, din, er, ep, ce, ex_out;
        string tag;
        case (cfg_clk_sel)
            3'd4: lvl = sh_clk_pt;
            3'd5: lvl = ind_clk_pt;
            3'd6: lvl = ~ind_clk_pt;
            3'd7: lvl = 1'b0;
            default: lvl = blk_clk[cfg_clk_sel[1:0]];
        endcase
        din = cfg_io_sel ? io_in : (logic_sum ^ cfg_xor_inv);
        er  = cfg_init_ind ? ind_rst_pt : sh_rst_pt;
        ep  = cfg_init_ind ? (ind_pre_ce_pt & ~cfg_ce_en) : sh_pre_pt;
        ce  = cfg_ce_en ? ind_pre_ce_pt : 1'b1;
        if (rst) begin
            exp_q = cfg_pwr_val; lvl = 1'b1; tag = "R1";
        end else if (er) begin
            exp_q = 1'b0; tag = "R8";
        end else if (ep) begin
            exp_q = 1'b1; tag = "R8";
        end else if (!ce) begin
            tag = "R7";
        end else begin
            case (cfg_mode)
                2'd1: begin if (lvl && !exp_prev && din) exp_q = ~exp_q; tag = "R4"; end
                2'd2: begin if (lvl) exp_q = din; tag = "R5"; end
                default: begin if (lvl && !exp_prev) exp_q = din; tag = "R3"; end
            endcase
            if (cfg_clk_sel == 3'd7) tag = "R6";
            else if (cfg_io_sel) tag = "R9";
        end
        exp_prev = lvl;
        ex_out = cfg_bypass ? (logic_sum ^ cfg_xor_inv) : exp_q;
        if (cfg_bypass) tag = "R2";
        @(posedge clk);
        @(negedge clk);
        check(tag, orp_out, ex_out);
        check("R10", grp_out, orp_out);
    endtask

    task automatic randomize_inputs();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        blk_clk       = rng[3:0];
        sh_clk_pt     = rng[4];
        ind_clk_pt    = rng[5];
        logic_sum     = rng[6];
        io_in         = rng[7];
        ind_pre_ce_pt = rng[8] | rng[26];
        cfg_ce_en     = rng[9];
        cfg_init_ind  = rng[10];
        cfg_bypass    = rng[11] & rng[12];
        sh_rst_pt     = (rng[17:14] == 4'd0);
        sh_pre_pt     = (rng[21:18] == 4'd0);
        ind_rst_pt    = (rng[25:22] == 4'd0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1: power-up value 1, then 0
        @(negedge clk);
        cfg_pwr_val = 1'b1;
        tick(); tick();
        cfg_pwr_val = 1'b0;
        tick();
        rst = 1'b0;

        // R2: bypass sweep over sum and polarity
        cfg_bypass = 1'b1;
        for (int s = 0; s < 4; s++) begin
            logic_sum = s[0]; cfg_xor_inv = s[1];
            tick();
        end
        cfg_bypass = 1'b0; cfg_xor_inv = 1'b0;

        // R8: shared reset and preset together, reset must win
        cfg_init_ind = 1'b0; sh_pre_pt = 1'b1;
        tick();
        sh_rst_pt = 1'b1;
        tick();
        sh_rst_pt = 1'b0; sh_pre_pt = 1'b0;

        // R8: individual terms, enable mode masks the preset
        cfg_init_ind = 1'b1; cfg_ce_en = 1'b1; ind_pre_ce_pt = 1'b1;
        cfg_clk_sel = 3'd7;
        tick();
        cfg_ce_en = 1'b0;
        tick();
        ind_rst_pt = 1'b1;
        tick();
        ind_rst_pt = 1'b0; ind_pre_ce_pt = 1'b0; cfg_init_ind = 1'b0;

        // R3 R4 R5 R6 R7 R9: sweep clock codes, modes, data path and polarity
        for (int cs = 0; cs < 8; cs++) begin
            for (int md = 0; md < 3; md++) begin
                for (int io = 0; io < 2; io++) begin
                    for (int iv = 0; iv < 2; iv++) begin
                        cfg_clk_sel = cs[2:0];
                        cfg_mode    = md[1:0];
                        cfg_io_sel  = io[0];
                        cfg_xor_inv = iv[0];
                        for (int st = 0; st < 14; st++) begin
                            randomize_inputs();
                            tick();
                        end
                    end
                end
            end
        end

        // R1: reset again mid-run with value 1
        rst = 1'b1; cfg_pwr_val = 1'b1; cfg_bypass = 1'b0;
        sh_rst_pt = 0; sh_pre_pt = 0; ind_rst_pt = 0;
        tick();
        rst = 1'b0;
        tick();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule